// File: doc/BRIEF.md
# Disk Controller Command Phase Sequencer

This block is the host-facing command engine of a floppy disk controller. The host talks to it through a one-byte data port and a read-only status byte. The host writes a command byte, and the block decodes the opcode from its low five bits. It then accepts exactly as many parameter bytes as that opcode needs. The assembled command goes to the execution logic with a one-cycle start pulse. When execution signals done, the block presents the returned result bytes to the host one at a time.

The status byte carries four handshake flags: request, direction, busy and non-DMA. It also carries four per-drive positioning flags supplied by the execution side. These flags always reflect the phase the block is in: command, execution or result. Two cases never reach the execution port. The timing-setup command is absorbed locally, and its only visible effect is the non-DMA flag. An unrecognised opcode is answered directly with a single invalid-command status byte. After every byte moved in either direction, the request flag drops for a fixed number of clocks. This gives the host a pacing point.

Top module: `fdc_cmd_seq`

## Requirements
- R1: `msr` is {request, direction, non-DMA, busy, drive_pos_busy[3:0]} from bit 7 down to bit 0. Direction 1 means controller to host. Bits 3..0 follow `drive_pos_busy` in the same cycle.
- R2: The opcode is bits 4..0 of the first byte, and bits 7..5 do not affect sequencing. The total command bytes per opcode are: 9 for 06h, 0Ch, 05h, 09h, 11h, 19h, 1Dh and 02h; 6 for 0Dh; 3 for 03h and 0Fh; 2 for 07h, 04h and 0Ah; 1 for 08h.
- R3: For every opcode except 03h and unrecognised ones, `exec_start` is high for exactly one cycle. This is the cycle after the last command byte is accepted. `exec_cmd` bits 8k+7..8k then hold command byte k, and the bytes beyond the command length are zero.
- R4: At `exec_done` in the execution phase, the block latches `exec_result` and enters the result phase (direction 1). This happens when the opcode returns results: 7 bytes for the 9-byte opcodes and for 0Ah and 0Dh, 2 for 08h and 1 for 04h. Result byte i is `exec_result` bits 8i+7..8i and is read in increasing i.
- R5: 0Fh and 07h have no result phase. At `exec_done` the block returns to the command phase with busy low.
- R6: 03h never pulses `exec_start`. Bit 0 of its third byte is copied into `msr` bit 5.
- R7: Busy rises when the first command byte is accepted. It stays high through execution and the result phase, and it clears after the last result byte is read (or at the end of 03h, 0Fh or 07h).
- R8: An unrecognised opcode gives no `exec_start` and no interrupt. The block returns one result byte, 80h.
- R9: `irq` rises on entry to a 7-byte result phase. Reading any result byte clears it. Opcodes 08h and 04h never raise it.
- R10: After each accepted write or read, request is low for exactly GAP_CLKS clocks.
- R11: A write is accepted only while request is 1 and direction is 0. A read advances only while both are 1. Other accesses change nothing.
- R12: A synchronous reset returns the block to an idle command phase: `msr[7:4]`=1000b, `irq` low, no pending start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe for the data port |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | Host read strobe for the data port |
| host_rdata | output | 8 | Current result byte |
| msr | output | 8 | Main status byte |
| drive_pos_busy | input | 4 | Per-drive positioning busy flags from execution |
| exec_start | output | 1 | One-cycle command start pulse |
| exec_cmd | output | 72 | Assembled command bytes, byte k at bits 8k+7..8k |
| exec_done | input | 1 | Execution finished; result bytes valid |
| exec_result | input | 56 | Result bytes, byte i at bits 8i+7..8i |
| irq | output | 1 | Interrupt request |

## Verification
Request falls at the edge that accepts a byte and rises again GAP_CLKS edges later. The bench therefore samples on the falling clock edge right after each access and again at the end of the gap. `exec_start` appears one edge after the last command byte. The result phase, with its interrupt, appears one edge after `exec_done`. The bench waits for these by polling request at falling edges under a timeout, rather than assuming fixed delays. Every expected byte count, result byte and flag comes from bench functions that restate the opcode table independently, and the random command mix also varies the execution latency.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
  localparam int BYTE_W  = 8;
  localparam int CMD_MAX = 9;
  localparam int RES_MAX = 7;
  localparam int CNT_W   = $clog2(CMD_MAX + 1);
  localparam int NDRIVE  = 4;
  localparam logic [BYTE_W-1:0] BAD_OP_ST0 = 8'h80;

  typedef enum logic [1:0] {PH_CMD, PH_EXEC, PH_RES} phase_t;

  typedef struct packed {
    logic             known;
    logic             local_only;
    logic             irq_class;
    logic [CNT_W-1:0] n_cmd;
    logic [CNT_W-1:0] n_res;
  } op_info_t;

  // Opcode table: command length, result length and class per 5-bit code
  function automatic op_info_t decode_op(input logic [4:0] op);
    op_info_t d;
    d = '{known: 1'b1, local_only: 1'b0, irq_class: 1'b0,
          n_cmd: CNT_W'(1), n_res: CNT_W'(0)};
    case (op)
      5'h02, 5'h05, 5'h06, 5'h09, 5'h0C, 5'h11, 5'h19, 5'h1D: begin
        d.n_cmd = CNT_W'(9); d.n_res = CNT_W'(7); d.irq_class = 1'b1;
      end
      5'h0A: begin d.n_cmd = CNT_W'(2); d.n_res = CNT_W'(7); d.irq_class = 1'b1; end
      5'h0D: begin d.n_cmd = CNT_W'(6); d.n_res = CNT_W'(7); d.irq_class = 1'b1; end
      5'h03: begin d.n_cmd = CNT_W'(3); d.local_only = 1'b1; end
      5'h0F: d.n_cmd = CNT_W'(3);
      5'h07: d.n_cmd = CNT_W'(2);
      5'h08: d.n_res = CNT_W'(2);
      5'h04: begin d.n_cmd = CNT_W'(2); d.n_res = CNT_W'(1); end
      default: begin d.known = 1'b0; d.n_res = CNT_W'(1); end
    endcase
    return d;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(
      input logic [RES_MAX*BYTE_W-1:0] flat, input logic [CNT_W-1:0] idx);
    logic [BYTE_W-1:0] b;
    b = '0;
    for (int k = 0; k < RES_MAX; k++)
      if (idx == CNT_W'(k)) b = flat[BYTE_W*k +: BYTE_W];
    return b;
  endfunction
endpackage

// File: rtl/fdc_seq_decode.sv
module fdc_seq_decode
  import fdc_seq_pkg::*;
(
  input  logic [4:0] opcode,
  output op_info_t   info
);
  assign info = decode_op(opcode);
endmodule

// File: rtl/fdc_seq_gap.sv
module fdc_seq_gap #(
  parameter int GAP_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic idle
);
  generate
    if (GAP_CLKS == 0) begin : g_none
      logic unused_in;
      assign unused_in = clk ^ rst ^ kick;
      assign idle = 1'b1;
    end else begin : g_timer
      localparam int GW = $clog2(GAP_CLKS + 1);
      logic [GW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (kick)         cnt <= GW'(GAP_CLKS);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
      end
      assign idle = (cnt == '0);
    end
  endgenerate
endmodule

// File: rtl/fdc_seq_cmdbuf.sv
module fdc_seq_cmdbuf
  import fdc_seq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      wr,
  input  logic [CNT_W-1:0]          idx,
  input  logic [BYTE_W-1:0]         din,
  output logic [CMD_MAX*BYTE_W-1:0] flat
);
  generate
    for (genvar k = 0; k < CMD_MAX; k++) begin : g_byte
      logic [BYTE_W-1:0] b;
      always_ff @(posedge clk) begin
        if (rst)                             b <= '0;
        else if (wr && idx == CNT_W'(k))     b <= din;
        else if (clear)                      b <= '0;
      end
      assign flat[BYTE_W*k +: BYTE_W] = b;
    end
  endgenerate
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_seq_pkg::*;
#(
  parameter int GAP_CLKS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      host_wr,
  input  logic [BYTE_W-1:0]         host_wdata,
  input  logic                      host_rd,
  output logic [BYTE_W-1:0]         host_rdata,
  output logic [BYTE_W-1:0]         msr,
  input  logic [NDRIVE-1:0]         drive_pos_busy,
  output logic                      exec_start,
  output logic [CMD_MAX*BYTE_W-1:0] exec_cmd,
  input  logic                      exec_done,
  input  logic [RES_MAX*BYTE_W-1:0] exec_result,
  output logic                      irq
);
  phase_t                    phase;
  logic [CNT_W-1:0]          cmd_idx, res_idx, need_q, res_need_q;
  logic                      local_q, irqcls_q, ndma_q, irq_q, start_q;
  logic [RES_MAX*BYTE_W-1:0] res_q;
  op_info_t                  new_info;
  logic                      gap_idle;

  // Named events, also observed by the checker
  logic rqm, dio, busy, wr_accept, rd_accept, first_byte, last_byte, res_last;
  logic [CNT_W-1:0] need_now;
  logic             local_now;

  assign rqm        = (phase != PH_EXEC) && gap_idle;
  assign dio        = (phase == PH_RES);
  assign busy       = (phase != PH_CMD) || (cmd_idx != '0);
  assign wr_accept  = host_wr && rqm && !dio;
  assign rd_accept  = host_rd && rqm && dio;
  assign first_byte = wr_accept && (cmd_idx == '0);
  assign need_now   = first_byte ? new_info.n_cmd : need_q;
  assign local_now  = first_byte ? new_info.local_only : local_q;
  assign last_byte  = wr_accept && (CNT_W'(cmd_idx + 1'b1) == need_now);
  assign res_last   = rd_accept && (CNT_W'(res_idx + 1'b1) == res_need_q);

  fdc_seq_decode u_dec (.opcode(host_wdata[4:0]), .info(new_info));

  fdc_seq_gap #(.GAP_CLKS(GAP_CLKS)) u_gap (
    .clk(clk), .rst(rst), .kick(wr_accept || rd_accept), .idle(gap_idle));

  fdc_seq_cmdbuf u_buf (
    .clk(clk), .rst(rst), .clear(first_byte), .wr(wr_accept),
    .idx(cmd_idx), .din(host_wdata), .flat(exec_cmd));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_CMD;
      cmd_idx    <= '0;
      res_idx    <= '0;
      need_q     <= '0;
      res_need_q <= '0;
      local_q    <= 1'b0;
      irqcls_q   <= 1'b0;
      ndma_q     <= 1'b0;
      irq_q      <= 1'b0;
      start_q    <= 1'b0;
      res_q      <= '0;
    end else begin
      start_q <= 1'b0;
      if (first_byte) begin
        need_q     <= new_info.n_cmd;
        res_need_q <= new_info.n_res;
        local_q    <= new_info.local_only;
        irqcls_q   <= new_info.irq_class;
      end
      if (wr_accept) begin
        if (last_byte) begin
          cmd_idx <= '0;
          if (first_byte && !new_info.known) begin
            phase   <= PH_RES;
            res_idx <= '0;
            res_q   <= {{(RES_MAX-1)*BYTE_W{1'b0}}, BAD_OP_ST0};
          end else if (local_now) begin
            ndma_q <= host_wdata[0];
          end else begin
            phase   <= PH_EXEC;
            start_q <= 1'b1;
          end
        end else begin
          cmd_idx <= cmd_idx + 1'b1;
        end
      end
      if (phase == PH_EXEC && exec_done) begin
        if (res_need_q == '0) begin
          phase <= PH_CMD;
        end else begin
          phase   <= PH_RES;
          res_q   <= exec_result;
          res_idx <= '0;
          irq_q   <= irqcls_q;
        end
      end
      if (rd_accept) begin
        irq_q <= 1'b0;
        if (res_last) begin
          phase   <= PH_CMD;
          res_idx <= '0;
        end else begin
          res_idx <= res_idx + 1'b1;
        end
      end
    end
  end

  assign host_rdata = pick_byte(res_q, res_idx);
  assign msr        = {rqm, dio, ndma_q, busy, drive_pos_busy};
  assign exec_start = start_q;
  assign irq        = irq_q;
endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] msr,
  input logic       irq,
  input logic       exec_start,
  input logic       wr_accept,
  input logic       rd_accept
);
  p_reset_idle_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (msr[7:4] == 4'b1000 && !irq && !exec_start));

  p_gap_after_write_r10: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> !msr[7]);

  p_gap_after_read_r10: assert property (@(posedge clk) disable iff (rst)
    rd_accept |=> !msr[7]);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
    rd_accept |=> !irq);

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> !exec_start);

  p_busy_in_result_r7: assert property (@(posedge clk) disable iff (rst)
    msr[6] |-> msr[4]);
endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk u_chk (
  .clk(clk), .rst(rst), .msr(msr), .irq(irq), .exec_start(exec_start),
  .wr_accept(wr_accept), .rd_accept(rd_accept));

// File: tb/tb_fdc_cmd_seq.sv
`timescale 1ns/1ps
module tb_fdc_cmd_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0, host_rdata, msr;
  logic [3:0]  drive_pos_busy = '0;
  logic        exec_start, exec_done = 1'b0, irq;
  logic [71:0] exec_cmd, cap_cmd = '0;
  logic [55:0] exec_result = '0, model_res = '0;
  int          checks = 0, errors = 0, start_cnt = 0, exec_delay = 2;
  logic [7:0]  sent [0:8];

  always #2.5 clk = ~clk;

  fdc_cmd_seq dut (.*);

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void shape(input logic [4:0] op, output int nc, output int nr,
                                output bit ir, output bit ex);
    ex = 1; ir = 0; nc = 1; nr = 0;
    if (op inside {5'h02, 5'h05, 5'h06, 5'h09, 5'h0C, 5'h11, 5'h19, 5'h1D}) begin nc = 9; nr = 7; ir = 1; end
    else if (op == 5'h0A) begin nc = 2; nr = 7; ir = 1; end
    else if (op == 5'h0D) begin nc = 6; nr = 7; ir = 1; end
    else if (op == 5'h03) begin nc = 3; ex = 0; end
    else if (op == 5'h0F) nc = 3;
    else if (op == 5'h07) nc = 2;
    else if (op == 5'h08) nr = 2;
    else if (op == 5'h04) begin nc = 2; nr = 1; end
    else begin nr = 1; ex = 0; end
  endfunction

  // Execution side model
  initial forever begin
    @(negedge clk);
    if (exec_start) begin
      cap_cmd = exec_cmd;
      start_cnt++;
      repeat (exec_delay) @(negedge clk);
      exec_result = model_res;
      exec_done = 1'b1;
      @(negedge clk);
      exec_done = 1'b0;
    end
  end

  task automatic wait_req();
    for (int t = 0; t < 300 && !msr[7]; t++) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] b);
    wait_req();
    host_wr = 1'b1; host_wdata = b;
    @(negedge clk);
    host_wr = 1'b0;
    chk(msr[7] == 1'b0, "R10 request low after write", msr[7], 0);
  endtask

  task automatic host_read(output logic [7:0] b);
    wait_req();
    b = host_rdata;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] b0, input bit poke_gap, input bit poke_res);
    int nc, nr, s0; bit ir, ex; logic [7:0] got, exp;
    shape(b0[4:0], nc, nr, ir, ex);
    sent[0] = b0;
    for (int k = 1; k < 9; k++) sent[k] = 8'($urandom);
    model_res = {$urandom, 24'($urandom)};
    exec_delay = 1 + ($urandom % 6);
    s0 = start_cnt;
    for (int i = 0; i < nc; i++) begin
      host_write(sent[i]);
      if (i == 0) chk(msr[4] == 1'b1, "R7 busy after first byte", msr, 8'h10);
      if (poke_gap && i < nc - 1) begin
        host_wr = 1'b1; host_wdata = 8'hEE;
        @(negedge clk);
        host_wr = 1'b0;
      end
    end
    if (nr > 0) begin
      wait_req();
      chk(msr[6] == 1'b1, "R4 direction in result phase", msr, 8'hC0);
      chk(irq == ir, "R9 irq on result entry", irq, ir);
      for (int i = 0; i < nr; i++) begin
        if (poke_res && i == 1) begin
          host_wr = 1'b1; host_wdata = 8'h55;
          @(negedge clk);
          host_wr = 1'b0;
          chk(msr[6] == 1'b1, "R11 write ignored in result phase", msr, 8'hC0);
        end
        host_read(got);
        exp = ex ? model_res[8*i +: 8] : 8'h80;
        chk(got == exp, ex ? "R4 result byte" : "R8 invalid status byte", got, exp);
        if (i == 0) chk(irq == 1'b0, "R9 irq cleared by read", irq, 0);
      end
      wait_req();
      chk(msr[6:4] == {1'b0, msr[5], 1'b0}, "R7 busy clear after last read", msr, 0);
    end else begin
      wait_req();
      chk(msr[6] == 1'b0 && msr[4] == 1'b0, "R5 back to command phase", msr, 8'h80);
    end
    chk(start_cnt == s0 + (ex ? 1 : 0),
        ex ? "R3 one start per command" : (nc == 1 ? "R8 no start" : "R6 no start"),
        start_cnt - s0, ex);
    if (ex) begin
      for (int k = 0; k < 9; k++) begin
        exp = (k < nc) ? sent[k] : 8'h00;
        chk(cap_cmd[8*k +: 8] == exp, "R2 R3 command byte", cap_cmd[8*k +: 8], exp);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ops [0:14];
    logic [7:0] b;
    ops = '{8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09,
            8'h0A, 8'h0C, 8'h0D, 8'h0F, 8'h11, 8'h19, 8'h1D};
    void'($urandom(32'd4711));
    do_reset();
    @(negedge clk);
    chk(msr == 8'h80, "R12 reset status", msr, 8'h80);
    chk(irq == 1'b0 && exec_start == 1'b0, "R12 reset outputs", {irq, exec_start}, 0);
    drive_pos_busy = 4'b1010;
    #1;
    chk(msr[3:0] == 4'b1010, "R1 drive flags", msr[3:0], 4'b1010);
    drive_pos_busy = 4'b0000;

    // R6 timing-setup command sets and clears non-DMA
    sent[0] = 8'h03;
    host_write(8'h03); host_write(8'hA1); host_write(8'h05);
    wait_req();
    chk(msr[5] == 1'b1, "R6 non-DMA set", msr, 8'hA0);
    host_write(8'hE3); host_write(8'h12); host_write(8'h04);
    wait_req();
    chk(msr[5] == 1'b0 && msr[4] == 1'b0, "R6 non-DMA cleared", msr, 8'h80);

    // R8 unrecognised opcodes with flag bits
    run_cmd(8'hFF, 0, 0);
    run_cmd(8'h0B, 0, 0);

    // R11 read while direction is 0 changes nothing
    @(negedge clk); host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
    chk(msr == 8'h80, "R11 read ignored in command phase", msr, 8'h80);

    // R10 gap length on the first byte of a positioning command
    host_write(8'h0F);
    @(negedge clk);
    chk(msr[7] == 1'b0, "R10 request still low", msr[7], 0);
    @(negedge clk);
    chk(msr[7] == 1'b1, "R10 request back after gap", msr[7], 1);
    host_write(8'h01); host_write(8'h22);
    wait_req();
    chk(msr[4] == 1'b0, "R5 positioning ends without results", msr, 8'h80);

    // R11 writes during gap and result phase ignored
    run_cmd(8'h46, 1, 1);
    run_cmd(8'h0D, 1, 0);

    // R12 reset in mid-command
    host_write(8'h06); host_write(8'h00);
    do_reset();
    @(negedge clk);
    chk(msr == 8'h80 && irq == 1'b0, "R12 reset mid-command", msr, 8'h80);
    run_cmd(8'h08, 0, 0);

    // Random mix: R2 flags ignored, R4 R9 per class
    for (int n = 0; n < 40; n++) begin
      b = ops[$urandom % 15];
      b[7:5] = 3'($urandom);
      run_cmd(b, ($urandom % 4) == 0, ($urandom % 4) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule